// File: doc/BRIEF.md
# Commit trace record generator

This block sits beside the retirement stage of an in-order pipeline and turns what happens there each cycle into an ordered stream of trace records. A record holds a program counter, an instruction word, a trap flag with cause and trap value, and at most one destination-register write. Instructions that finish in one cycle are reported at retirement with their own write. Long-latency instructions, such as divides, retire with no result. Their destination, PC and instruction word are parked in a four-entry pending table. When the result later arrives on the late-writeback port, it is reported under the PC and instruction word of the instruction that produced it. It is never reported under the PC of whatever instruction happens to retire in that cycle.

A cycle can produce two records: a late writeback and a retirement, which may be a trap. The writeback record always comes out first. Records leave through an output register backed by a one-entry skid register. A three-state controller runs them:

- Q_EMPTY: nothing is held. It goes to Q_ONE on one push and to Q_TWO on two pushes.
- Q_ONE: the output register is full. On a pop it goes to Q_EMPTY, stays in Q_ONE, or goes to Q_TWO, for zero, one or two pushes.
- Q_TWO: both registers are full. A pop moves the skid entry forward and returns to Q_ONE.

`stall` tells the retire source to hold back. `wb_hold` tells the long-latency units to hold back.

Top module: `commit_trace_gen`

## Requirements
- R1: After reset, out_valid, stall, wb_hold and wb_err are all low.
- R2: An accepted non-trap, non-long retirement emits one record with its own PC and instruction word, trap=0, and cause and tval zero. If ret_wen is set and ret_rd is nonzero, the record also has wen=1 with ret_rd and ret_wdata. Otherwise it has wen=0 with rd and wdata zero.
- R3: A write to register 0 is never reported. A retirement writing register 0 gets wen=0. A late writeback to register 0 makes no record and raises no error.
- R4: An accepted retirement with ret_trap=1 emits a record with trap=1 and its own PC, instruction word, cause and tval, for example cause 4 for a misaligned load. The record has wen=0 even when ret_wen is set, and it never creates a pending entry.
- R5: An accepted non-trap retirement with ret_long=1 and a nonzero ret_rd emits no record. It stores rd, PC and instruction word in a free pending entry.
- R6: An accepted late writeback whose rd matches a pending entry emits a record with that entry's PC and instruction word, trap=0, wen=1, wb_rd and wb_data. It then frees the entry.
- R7: When a late writeback record and a retirement record arise in the same cycle, both are emitted, and the writeback record leaves first.
- R8: wb_err is high in a cycle where wb_valid is set, wb_hold is low, wb_rd is nonzero and no pending entry matches. No record is made.
- R9: stall is high while all four pending entries are in use.
- R10: While out_valid is high and out_ready is low, the record fields hold steady. stall and wb_hold are high when the output path cannot take more, that is in Q_TWO, or in Q_ONE without out_ready. Retirements offered while stall is high, and writebacks offered while wb_hold is high, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | 32 | PC of the retiring instruction |
| ret_insn | input | 32 | Instruction word of the retiring instruction |
| ret_trap | input | 1 | The retiring instruction traps |
| ret_cause | input | 5 | Trap cause code |
| ret_tval | input | 32 | Trap value |
| ret_wen | input | 1 | Single-cycle register write at retirement |
| ret_long | input | 1 | Result will arrive later on the writeback port |
| ret_rd | input | 5 | Destination register |
| ret_wdata | input | 32 | Write data for a single-cycle write |
| wb_valid | input | 1 | Late writeback arrives |
| wb_rd | input | 5 | Late writeback destination |
| wb_data | input | 32 | Late writeback data |
| out_ready | input | 1 | Consumer takes the record |
| out_valid | output | 1 | A record is presented |
| out_pc | output | 32 | Record PC |
| out_insn | output | 32 | Record instruction word |
| out_trap | output | 1 | Record is a trap |
| out_cause | output | 5 | Record cause (0 if not a trap) |
| out_tval | output | 32 | Record trap value (0 if not a trap) |
| out_wen | output | 1 | Record carries a register write |
| out_rd | output | 5 | Record destination (0 without a write) |
| out_wdata | output | 32 | Record write data (0 without a write) |
| stall | output | 1 | Retire source must hold |
| wb_hold | output | 1 | Late writeback source must hold |
| wb_err | output | 1 | Late writeback matched no pending entry |

## Verification
Plain retirements with and without writes, including writes to register 0, check that a record takes its fields only from its own instruction. The key pattern is a divide parked in the table and then completed in the very cycle a misaligned load traps with cause 4. It tells correct attribution apart from a merged record: the output must be two records, the divide's PC first, and no write on the trap. A repeated writeback to an already freed register separates freeing from mere lookup. Filling the table and holding out_ready low in Q_ONE and in Q_TWO, while still offering input, check the stall conditions, that the held record does not change, and that ignored inputs leave no trace in the record stream.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
    localparam int PC_W    = 32;
    localparam int INSN_W  = 32;
    localparam int DATA_W  = 32;
    localparam int CAUSE_W = 5;
    localparam int TVAL_W  = 32;
    localparam int REG_W   = 5;

    typedef struct packed {
        logic [PC_W-1:0]    pc;
        logic [INSN_W-1:0]  insn;
        logic               trap;
        logic [CAUSE_W-1:0] cause;
        logic [TVAL_W-1:0]  tval;
        logic               wen;
        logic [REG_W-1:0]   rd;
        logic [DATA_W-1:0]  wdata;
    } trace_rec_t;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_ONE   = 2'd1,
        Q_TWO   = 2'd2
    } q_state_t;
endpackage

// File: rtl/ctg_pend_table.sv
module ctg_pend_table
    import ctg_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_W-1:0]    look_rd,
    input  logic                free_en,
    input  logic                alloc_en,
    input  logic [REG_W-1:0]    alloc_rd,
    input  logic [PC_W-1:0]     alloc_pc,
    input  logic [INSN_W-1:0]   alloc_insn,
    output logic                hit,
    output logic [PC_W-1:0]     hit_pc,
    output logic [INSN_W-1:0]   hit_insn,
    output logic                full
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  vld;
    logic [REG_W-1:0]  rd_q   [DEPTH];
    logic [PC_W-1:0]   pc_q   [DEPTH];
    logic [INSN_W-1:0] insn_q [DEPTH];
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  free_idx;

    // lowest matching entry wins; lowest empty entry is allocated
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld[i] && rd_q[i] == look_rd) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!vld[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign full     = &vld;
    assign hit_pc   = pc_q[hit_idx];
    assign hit_insn = insn_q[hit_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (free_en) begin
                vld[hit_idx] <= 1'b0;
            end
            if (alloc_en) begin
                vld[free_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            rd_q[free_idx]   <= alloc_rd;
            pc_q[free_idx]   <= alloc_pc;
            insn_q[free_idx] <= alloc_insn;
        end
    end

    // R9
    no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !full);

    // R6
    free_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> hit);
endmodule

// File: rtl/ctg_rec_build.sv
module ctg_rec_build
    import ctg_pkg::*;
(
    input  logic                ret_acc,
    input  logic                wb_acc,
    input  logic                ret_valid,
    input  logic [PC_W-1:0]     ret_pc,
    input  logic [INSN_W-1:0]   ret_insn,
    input  logic                ret_trap,
    input  logic [CAUSE_W-1:0]  ret_cause,
    input  logic [TVAL_W-1:0]   ret_tval,
    input  logic                ret_wen,
    input  logic                ret_long,
    input  logic [REG_W-1:0]    ret_rd,
    input  logic [DATA_W-1:0]   ret_wdata,
    input  logic                wb_valid,
    input  logic [REG_W-1:0]    wb_rd,
    input  logic [DATA_W-1:0]   wb_data,
    input  logic                hit,
    input  logic [PC_W-1:0]     hit_pc,
    input  logic [INSN_W-1:0]   hit_insn,
    output logic [1:0]          push_n,
    output trace_rec_t          rec0,
    output trace_rec_t          rec1,
    output logic                alloc_en,
    output logic                free_en,
    output logic                miss_err
);
    logic       wb_act, ret_act, ret_rec_v, wr_ok;
    trace_rec_t wb_rec, ret_rec;

    assign wb_act    = wb_acc && wb_valid && (wb_rd != '0);
    assign free_en   = wb_act && hit;
    assign miss_err  = wb_act && !hit;
    assign ret_act   = ret_acc && ret_valid;
    assign alloc_en  = ret_act && !ret_trap && ret_long && (ret_rd != '0);
    assign ret_rec_v = ret_act && !alloc_en;
    assign wr_ok     = !ret_trap && !ret_long && ret_wen && (ret_rd != '0);

    always_comb begin
        wb_rec       = '0;
        wb_rec.pc    = hit_pc;
        wb_rec.insn  = hit_insn;
        wb_rec.wen   = 1'b1;
        wb_rec.rd    = wb_rd;
        wb_rec.wdata = wb_data;

        ret_rec       = '0;
        ret_rec.pc    = ret_pc;
        ret_rec.insn  = ret_insn;
        ret_rec.trap  = ret_trap;
        ret_rec.cause = ret_trap ? ret_cause : '0;
        ret_rec.tval  = ret_trap ? ret_tval : '0;
        ret_rec.wen   = wr_ok;
        ret_rec.rd    = wr_ok ? ret_rd : '0;
        ret_rec.wdata = wr_ok ? ret_wdata : '0;

        // the writeback record always goes out ahead of the retirement record
        if (free_en) begin
            rec0 = wb_rec;
            rec1 = ret_rec;
        end else begin
            rec0 = ret_rec;
            rec1 = '0;
        end
        push_n = {1'b0, free_en} + {1'b0, ret_rec_v};
    end
endmodule

// File: rtl/ctg_out_queue.sv
module ctg_out_queue
    import ctg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  push_n,
    input  trace_rec_t  rec0,
    input  trace_rec_t  rec1,
    input  logic        out_ready,
    output logic        out_valid,
    output trace_rec_t  out_rec,
    output logic        busy
);
    q_state_t   state, state_nxt;
    trace_rec_t skid_rec;
    logic       pop, load_out, load_skid, from_skid;

    assign pop = out_valid && out_ready;

    always_comb begin
        state_nxt = state;
        load_out  = 1'b0;
        load_skid = 1'b0;
        from_skid = 1'b0;
        unique case (state)
            Q_EMPTY: begin
                if (push_n == 2'd1) begin
                    state_nxt = Q_ONE;
                    load_out  = 1'b1;
                end else if (push_n == 2'd2) begin
                    state_nxt = Q_TWO;
                    load_out  = 1'b1;
                    load_skid = 1'b1;
                end
            end
            Q_ONE: begin
                if (pop) begin
                    if (push_n == 2'd0) begin
                        state_nxt = Q_EMPTY;
                    end else if (push_n == 2'd1) begin
                        load_out  = 1'b1;
                    end else begin
                        state_nxt = Q_TWO;
                        load_out  = 1'b1;
                        load_skid = 1'b1;
                    end
                end
            end
            Q_TWO: begin
                if (pop) begin
                    state_nxt = Q_ONE;
                    load_out  = 1'b1;
                    from_skid = 1'b1;
                end
            end
            default: state_nxt = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_rec  <= '0;
            skid_rec <= '0;
        end else begin
            if (load_out) begin
                out_rec <= from_skid ? skid_rec : rec0;
            end
            if (load_skid) begin
                skid_rec <= rec1;
            end
        end
    end

    assign out_valid = (state != Q_EMPTY);
    assign busy      = (state == Q_TWO) || (state == Q_ONE && !out_ready);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_rec));

    // R10
    no_push_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> push_n == 2'd0);
endmodule

// File: rtl/commit_trace_gen.sv
module commit_trace_gen
    import ctg_pkg::*;
#(
    parameter int PEND_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ret_valid,
    input  logic [PC_W-1:0]     ret_pc,
    input  logic [INSN_W-1:0]   ret_insn,
    input  logic                ret_trap,
    input  logic [CAUSE_W-1:0]  ret_cause,
    input  logic [TVAL_W-1:0]   ret_tval,
    input  logic                ret_wen,
    input  logic                ret_long,
    input  logic [REG_W-1:0]    ret_rd,
    input  logic [DATA_W-1:0]   ret_wdata,
    input  logic                wb_valid,
    input  logic [REG_W-1:0]    wb_rd,
    input  logic [DATA_W-1:0]   wb_data,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [PC_W-1:0]     out_pc,
    output logic [INSN_W-1:0]   out_insn,
    output logic                out_trap,
    output logic [CAUSE_W-1:0]  out_cause,
    output logic [TVAL_W-1:0]   out_tval,
    output logic                out_wen,
    output logic [REG_W-1:0]    out_rd,
    output logic [DATA_W-1:0]   out_wdata,
    output logic                stall,
    output logic                wb_hold,
    output logic                wb_err
);
    logic             q_busy, tbl_full, hit, alloc_en, free_en;
    logic [PC_W-1:0]  hit_pc;
    logic [INSN_W-1:0] hit_insn;
    logic [1:0]       push_n;
    trace_rec_t       rec0, rec1, out_rec;

    assign stall   = tbl_full || q_busy;
    assign wb_hold = q_busy;

    ctg_pend_table #(.DEPTH(PEND_DEPTH)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_rd    (wb_rd),
        .free_en    (free_en),
        .alloc_en   (alloc_en),
        .alloc_rd   (ret_rd),
        .alloc_pc   (ret_pc),
        .alloc_insn (ret_insn),
        .hit        (hit),
        .hit_pc     (hit_pc),
        .hit_insn   (hit_insn),
        .full       (tbl_full)
    );

    ctg_rec_build u_build (
        .ret_acc   (!stall),
        .wb_acc    (!wb_hold),
        .ret_valid (ret_valid),
        .ret_pc    (ret_pc),
        .ret_insn  (ret_insn),
        .ret_trap  (ret_trap),
        .ret_cause (ret_cause),
        .ret_tval  (ret_tval),
        .ret_wen   (ret_wen),
        .ret_long  (ret_long),
        .ret_rd    (ret_rd),
        .ret_wdata (ret_wdata),
        .wb_valid  (wb_valid),
        .wb_rd     (wb_rd),
        .wb_data   (wb_data),
        .hit       (hit),
        .hit_pc    (hit_pc),
        .hit_insn  (hit_insn),
        .push_n    (push_n),
        .rec0      (rec0),
        .rec1      (rec1),
        .alloc_en  (alloc_en),
        .free_en   (free_en),
        .miss_err  (wb_err)
    );

    ctg_out_queue u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (push_n),
        .rec0      (rec0),
        .rec1      (rec1),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_rec   (out_rec),
        .busy      (q_busy)
    );

    assign out_pc    = out_rec.pc;
    assign out_insn  = out_rec.insn;
    assign out_trap  = out_rec.trap;
    assign out_cause = out_rec.cause;
    assign out_tval  = out_rec.tval;
    assign out_wen   = out_rec.wen;
    assign out_rd    = out_rec.rd;
    assign out_wdata = out_rec.wdata;

    // R4
    trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_trap |-> !out_wen);

    // R3
    no_x0_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_wen |-> out_rd != '0);

    // R8
    err_no_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err |-> !free_en && !wb_hold);
endmodule

// File: tb/commit_trace_gen_tb.sv
module commit_trace_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ret_valid, ret_trap, ret_wen, ret_long;
    logic [31:0] ret_pc, ret_insn, ret_tval, ret_wdata;
    logic [4:0]  ret_cause, ret_rd;
    logic        wb_valid;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data;
    logic        out_ready;
    logic        out_valid, out_trap, out_wen, stall, wb_hold, wb_err;
    logic [31:0] out_pc, out_insn, out_tval, out_wdata;
    logic [4:0]  out_cause, out_rd;

    always #10 clk = ~clk;

    commit_trace_gen u_dut (.*);

    typedef struct {
        logic [31:0] pc; logic [31:0] insn; logic trap; logic [4:0] cause;
        logic [31:0] tval; logic wen; logic [4:0] rd; logic [31:0] wdata;
    } rec_t;

    rec_t        mq[$];
    logic [4:0]  pend_rd[$];
    logic [31:0] pend_pc[$];
    logic [31:0] pend_insn[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        ret_valid = 0; ret_trap = 0; ret_wen = 0; ret_long = 0;
        ret_pc = 0; ret_insn = 0; ret_tval = 0; ret_wdata = 0; ret_cause = 0; ret_rd = 0;
        wb_valid = 0; wb_rd = 0; wb_data = 0;
    endtask

    task automatic ret(logic [31:0] pc, logic [31:0] insn, logic trap, logic [4:0] cause,
                       logic [31:0] tval, logic wen, logic lng, logic [4:0] rd, logic [31:0] d);
        ret_valid = 1; ret_pc = pc; ret_insn = insn; ret_trap = trap; ret_cause = cause;
        ret_tval = tval; ret_wen = wen; ret_long = lng; ret_rd = rd; ret_wdata = d;
    endtask

    task automatic wb(logic [4:0] rd, logic [31:0] d);
        wb_valid = 1; wb_rd = rd; wb_data = d;
    endtask

    // one cycle: check outputs against the model, let the edge pass, update the model
    task automatic tick(string tag);
        bit  exp_v, busy, exp_stall, exp_err;
        int  idx;
        rec_t r;
        #5;
        exp_v     = mq.size() != 0;
        busy      = mq.size() == 2 || (mq.size() == 1 && !out_ready);
        exp_stall = pend_rd.size() == 4 || busy;
        idx = -1;
        for (int i = pend_rd.size() - 1; i >= 0; i--)
            if (pend_rd[i] == wb_rd) idx = i;
        exp_err = !busy && wb_valid && wb_rd != 0 && idx < 0;
        chk(tag, "out_valid", out_valid, exp_v);
        chk(tag, "stall", stall, exp_stall);
        chk(tag, "wb_hold", wb_hold, busy);
        chk(tag, "wb_err", wb_err, exp_err);
        if (exp_v) begin
            chk(tag, "pc", out_pc, mq[0].pc);
            chk(tag, "insn", out_insn, mq[0].insn);
            chk(tag, "trap", out_trap, mq[0].trap);
            chk(tag, "cause", out_cause, mq[0].cause);
            chk(tag, "tval", out_tval, mq[0].tval);
            chk(tag, "wen", out_wen, mq[0].wen);
            chk(tag, "rd", out_rd, mq[0].rd);
            chk(tag, "wdata", out_wdata, mq[0].wdata);
        end
        @(posedge clk);
        if (exp_v && out_ready) void'(mq.pop_front());
        if (!busy && wb_valid && wb_rd != 0 && idx >= 0) begin
            r = '{pend_pc[idx], pend_insn[idx], 0, 0, 0, 1, wb_rd, wb_data};
            mq.push_back(r);
            pend_rd.delete(idx); pend_pc.delete(idx); pend_insn.delete(idx);
        end
        if (!exp_stall && ret_valid) begin
            if (!ret_trap && ret_long && ret_rd != 0) begin
                pend_rd.push_back(ret_rd); pend_pc.push_back(ret_pc); pend_insn.push_back(ret_insn);
            end else begin
                r.pc = ret_pc; r.insn = ret_insn; r.trap = ret_trap;
                r.cause = ret_trap ? ret_cause : 5'd0;
                r.tval  = ret_trap ? ret_tval : 32'd0;
                r.wen   = !ret_trap && !ret_long && ret_wen && ret_rd != 0;
                r.rd    = r.wen ? ret_rd : 5'd0;
                r.wdata = r.wen ? ret_wdata : 32'd0;
                mq.push_back(r);
            end
        end
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        out_ready = 1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset stall", stall, 0);
        chk("R1", "reset wb_err", wb_err, 0);
        rst_n = 1;
        tick("R1");
        // R2 plain retirements
        ret(32'h100, 32'h00a00093, 0, 0, 0, 1, 0, 5'd1, 32'ha); tick("R2");
        ret(32'h104, 32'h00000013, 0, 0, 0, 0, 0, 5'd0, 32'h0); tick("R2");
        // R3 write to x0
        ret(32'h108, 32'h00500013, 0, 0, 0, 1, 0, 5'd0, 32'h5); tick("R3");
        // R4 trap with wen set must not carry a write
        ret(32'h10c, 32'h01032987, 1, 5'd4, 32'h12345673, 1, 0, 5'd3, 32'h99); tick("R4");
        tick("R4"); tick("R4");
        // R5 long-latency instruction parks
        ret(32'h2e4, 32'h02f7499b, 0, 0, 0, 0, 1, 5'd19, 0); tick("R5");
        tick("R5");
        ret(32'h2e8, 32'h00100213, 0, 0, 0, 1, 0, 5'd4, 32'h1); tick("R2");
        // R7 writeback in the same cycle as a misaligned-load trap
        ret(32'h2f2, 32'h01032987, 1, 5'd4, 32'h80000016, 0, 0, 5'd19, 0);
        wb(5'd19, 32'hffffffff); tick("R7");
        tick("R7"); tick("R7"); tick("R7");
        // R8 / R6 entry was freed: second writeback misses
        wb(5'd19, 32'h1); tick("R8");
        tick("R8");
        // R3 writeback to x0: no record, no error
        wb(5'd0, 32'h7); tick("R3");
        // R9 fill the table
        for (int i = 0; i < 4; i++) begin
            ret(32'h300 + 32'(4 * i), 32'h02000033 + 32'(i), 0, 0, 0, 0, 1, 5'(5 + i), 0);
            tick("R9");
        end
        tick("R9");
        // R10 retirement offered during stall is ignored
        ret(32'h400, 32'h00900493, 0, 0, 0, 1, 0, 5'd9, 32'h9); tick("R10");
        tick("R10");
        // R6 writeback accepted while table full
        wb(5'd7, 32'h77); tick("R6");
        tick("R6");
        ret(32'h404, 32'h02000133, 0, 0, 0, 0, 1, 5'd10, 0); tick("R5");
        ret(32'h500, 32'h00b00593, 0, 0, 0, 1, 0, 5'd11, 32'hb);
        wb(5'd5, 32'h55); tick("R7");
        tick("R7"); tick("R7");
        // R10 backpressure in Q_ONE
        out_ready = 0;
        ret(32'h600, 32'h00c00613, 0, 0, 0, 1, 0, 5'd12, 32'hc); tick("R10");
        ret(32'h604, 32'h00d00693, 0, 0, 0, 1, 0, 5'd13, 32'hd); tick("R10");
        wb(5'd6, 32'h66); tick("R10");
        tick("R10");
        out_ready = 1;
        tick("R10"); tick("R10");
        // R10 backpressure in Q_TWO
        ret(32'h700, 32'h00402003, 1, 5'd5, 32'h3, 0, 0, 5'd0, 0);
        wb(5'd6, 32'h66); tick("R7");
        out_ready = 0;
        tick("R10"); tick("R10");
        out_ready = 1;
        tick("R10"); tick("R10"); tick("R10");
        wb(5'd8, 32'h88); tick("R6");
        wb(5'd10, 32'haa); tick("R6");
        tick("R6"); tick("R6"); tick("R6");
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule